// File: doc/BRIEF.md
# Committed Load Forwarding Buffer

This block keeps a record of every load that a speculative, out-of-order core sends to its data cache, and passes to a downstream log only those loads that the core has architecturally committed, in program order. A record is opened when the core issues the load address to the cache. It is completed when the cache returns the load data on a return channel of its own, separate from the data path into the core. Because the cache may return data in any order, records fill out of order. They leave strictly from the oldest end, and only after the core reports that the load committed.

The storage is a circular queue whose slot index is the core's load-queue tag. When the core squashes a speculative path, it names the oldest squashed load. The tail pointer is wound back to that slot and every younger record is discarded, so a mis-speculated load can never reach the log. A full flag tells the core to hold further load issue while every slot is occupied. The output is a one-cycle valid pulse per released load, carrying its tag, address and data.

Top module: `commit_load_fwd_buf`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the buffer is empty: `out_valid` and `full` are 0.
- R2: An allocation is accepted only when `alloc_tag` equals the slot at the tail, the buffer is not full and no flush is requested in the same cycle. The address is stored in that slot and the tail advances by one. An allocation with any other tag is ignored.
- R3: `full` is 1 exactly when all 2^TAG_W slots are occupied. While full, allocations are ignored.
- R4: A fill writes `fill_data` into slot `fill_tag` only if that slot is occupied and still waiting for data. A fill to a free slot or to a slot that already holds data is ignored, and the first data is kept.
- R5: The oldest record is released when it is both filled and committed. `out_valid` is high, with that record's address and data, in the second cycle after the later of its fill cycle and its commit cycle, provided no older record remains.
- R6: Released records appear in program order. `out_tag` equals the slot index (the low TAG_W bits of the tag), and consecutive releases carry consecutive tags modulo 2^TAG_W, whatever order the fills arrived in. At most one record is released per cycle.
- R7: A record that is committed but not yet filled blocks the output. Nothing is released, for that record or any younger one, until its data arrives.
- R8: A flush whose `flush_tag` lies among the occupied slots moves the tail to `flush_tag`. That slot and every younger slot are freed and never released. The next accepted allocation uses `flush_tag`.
- R9: A flush whose `flush_tag` is not an occupied slot is ignored.
- R10: When a flush and an allocation arrive in the same cycle, the flush is applied and the allocation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A load address is being issued to the cache |
| alloc_tag | input | TAG_W | Load-queue tag of the issued load |
| alloc_addr | input | ADDR_W | Load address |
| full | output | 1 | Every slot is occupied; the core must hold load issue |
| fill_valid | input | 1 | Data is returning on the duplicate cache channel |
| fill_tag | input | TAG_W | Tag of the load whose data is returning |
| fill_data | input | DATA_W | Returned load data |
| commit_valid | input | 1 | A load has committed in the core |
| commit_tag | input | TAG_W | Tag of the committed load |
| flush_valid | input | 1 | The core squashes speculative loads |
| flush_tag | input | TAG_W | Tag of the oldest squashed load |
| out_valid | output | 1 | One committed load is released to the log this cycle |
| out_tag | output | TAG_W | Tag of the released load |
| out_addr | output | ADDR_W | Address of the released load |
| out_data | output | DATA_W | Data of the released load |

## Verification
The hardest cases to reach involve a squash that meets other events in the same cycle. One is a flush that lands on the very slot that a commit or a fill is also writing. Another is a flush that arrives together with an allocation, or a flush that rolls back across the wrap of the circular index. The stimulus reaches these by driving a long stream in which allocation, out-of-order fills, in-order commits and occasional squashes aimed anywhere in the uncommitted range all coincide freely. A behavioural model checks the output on every cycle. Directed sequences before this stream set up the committed-but-unfilled stall, the full buffer, the wrong-tag allocation and the out-of-range flush on purpose.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_PEND   = 2'd1,
        SLOT_FILLED = 2'd2
    } slot_st_e;

    // Operations accepted in one cycle, decided by the pointer control.
    typedef struct packed {
        logic alloc;
        logic flush;
        logic pop;
    } lfb_ops_t;

endpackage

// File: rtl/lfb_ptr_ctrl.sv
module lfb_ptr_ctrl
    import lfb_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_valid,
    input  logic [TAG_W-1:0]         alloc_tag,
    input  logic                     flush_valid,
    input  logic [TAG_W-1:0]         flush_tag,
    input  logic                     head_ready,
    output logic [TAG_W:0]           head_ptr,
    output logic [TAG_W:0]           tail_ptr,
    output logic [TAG_W-1:0]         head_idx,
    output logic                     full,
    output lfb_ops_t                 ops,
    output logic [(1<<TAG_W)-1:0]    kill_mask
);
    localparam int DEPTH = 1 << TAG_W;

    logic [TAG_W:0]   head_q, tail_q, used;
    logic [TAG_W-1:0] flush_dist;
    logic             empty;

    assign used       = tail_q - head_q;
    assign full       = used[TAG_W];
    assign empty      = (used == '0);
    assign head_idx   = head_q[TAG_W-1:0];
    assign flush_dist = flush_tag - head_idx;
    assign head_ptr   = head_q;
    assign tail_ptr   = tail_q;

    always_comb begin
        ops.flush = flush_valid && ({1'b0, flush_dist} < used);
        ops.alloc = alloc_valid && !full && !flush_valid
                    && (alloc_tag == tail_q[TAG_W-1:0]);
        ops.pop   = head_ready && !empty
                    && !(ops.flush && (flush_dist == '0));
    end

    // A slot dies on a squash when it sits at or beyond the squash point
    // and inside the occupied range, counted from the head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_kill
        localparam logic [TAG_W-1:0] SLOT = TAG_W'(g);
        logic [TAG_W-1:0] slot_dist;
        assign slot_dist   = SLOT - head_idx;
        assign kill_mask[g] = ops.flush && (slot_dist >= flush_dist)
                              && ({1'b0, slot_dist} < used);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + {{TAG_W{1'b0}}, ops.pop};
            if (ops.flush)
                tail_q <= head_q + {1'b0, flush_dist};
            else
                tail_q <= tail_q + {{TAG_W{1'b0}}, ops.alloc};
        end
    end

endmodule

// File: rtl/lfb_slot_array.sv
module lfb_slot_array
    import lfb_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  lfb_ops_t               ops,
    input  logic [(1<<TAG_W)-1:0]  kill_mask,
    input  logic [TAG_W-1:0]       head_idx,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic [ADDR_W-1:0]      alloc_addr,
    input  logic                   fill_valid,
    input  logic [TAG_W-1:0]       fill_tag,
    input  logic [DATA_W-1:0]      fill_data,
    input  logic                   commit_valid,
    input  logic [TAG_W-1:0]       commit_tag,
    output logic                   head_ready,
    output logic [ADDR_W-1:0]      head_addr,
    output logic [DATA_W-1:0]      head_data
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0]  ready_vec;
    logic [ADDR_W-1:0] addr_arr [DEPTH];
    logic [DATA_W-1:0] data_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [TAG_W-1:0] SLOT = TAG_W'(g);
        slot_st_e          st_q;
        logic              cm_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] data_q;
        logic              is_pop, is_alloc, is_fill, is_commit;

        assign is_pop    = ops.pop && (head_idx == SLOT);
        assign is_alloc  = ops.alloc && (alloc_tag == SLOT);
        assign is_fill   = fill_valid && (fill_tag == SLOT) && (st_q == SLOT_PEND);
        assign is_commit = commit_valid && (commit_tag == SLOT) && (st_q != SLOT_FREE);

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= SLOT_FREE;
                cm_q <= 1'b0;
            end else if (kill_mask[g] || is_pop) begin
                st_q <= SLOT_FREE;
                cm_q <= 1'b0;
            end else if (is_alloc) begin
                st_q <= SLOT_PEND;
                cm_q <= 1'b0;
            end else begin
                if (is_fill)
                    st_q <= SLOT_FILLED;
                if (is_commit)
                    cm_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q <= '0;
                data_q <= '0;
            end else begin
                if (is_alloc && !kill_mask[g])
                    addr_q <= alloc_addr;
                if (is_fill && !kill_mask[g] && !is_pop)
                    data_q <= fill_data;
            end
        end

        assign ready_vec[g] = (st_q == SLOT_FILLED) && cm_q;
        assign addr_arr[g]  = addr_q;
        assign data_arr[g]  = data_q;
    end

    assign head_ready = ready_vec[head_idx];
    assign head_addr  = addr_arr[head_idx];
    assign head_data  = data_arr[head_idx];

endmodule

// File: rtl/lfb_release.sv
module lfb_release #(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic [TAG_W-1:0]  head_idx,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) begin
                out_tag  <= head_idx;
                out_addr <= head_addr;
                out_data <= head_data;
            end
        end
    end
endmodule

// File: rtl/commit_load_fwd_buf.sv
module commit_load_fwd_buf
    import lfb_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              full,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              commit_valid,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              flush_valid,
    input  logic [TAG_W-1:0]  flush_tag,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    localparam int DEPTH = 1 << TAG_W;

    lfb_ops_t          ops;
    logic [DEPTH-1:0]  kill_mask;
    logic [TAG_W:0]    head_ptr, tail_ptr;
    logic [TAG_W-1:0]  head_idx;
    logic              head_ready;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;

    lfb_ptr_ctrl #(.TAG_W(TAG_W)) u_ptr (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .head_ready(head_ready),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr), .head_idx(head_idx),
        .full(full), .ops(ops), .kill_mask(kill_mask)
    );

    lfb_slot_array #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
        .clk(clk), .rst(rst), .ops(ops), .kill_mask(kill_mask),
        .head_idx(head_idx),
        .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .head_ready(head_ready), .head_addr(head_addr), .head_data(head_data)
    );

    lfb_release #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rel (
        .clk(clk), .rst(rst), .pop(ops.pop),
        .head_idx(head_idx), .head_addr(head_addr), .head_data(head_data),
        .out_valid(out_valid), .out_tag(out_tag),
        .out_addr(out_addr), .out_data(out_data)
    );

endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             flush_valid,
    input logic [TAG_W-1:0] flush_tag,
    input logic             full,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic [TAG_W:0]   head_ptr,
    input logic [TAG_W:0]   tail_ptr
);
    logic [TAG_W:0]   occ;
    logic [TAG_W-1:0] fl_off;
    logic             fl_hit;

    assign occ    = tail_ptr - head_ptr;
    assign fl_off = flush_tag - head_ptr[TAG_W-1:0];
    assign fl_hit = ({1'b0, fl_off} < occ);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !full && occ == '0));

    assert_bad_tag_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_tag != tail_ptr[TAG_W-1:0]) |=> (occ <= $past(occ)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        full |=> (occ <= $past(occ)));

    assert_program_order_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_tag == TAG_W'($past(out_tag) + 1'b1)));

    assert_flush_rollback_R8: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && fl_hit) |=> (tail_ptr[TAG_W-1:0] == $past(flush_tag)));

    assert_flush_miss_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !fl_hit) |=> (tail_ptr == $past(tail_ptr)));

    assert_flush_beats_alloc_R10: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> (occ <= $past(occ)));

endmodule

bind commit_load_fwd_buf lfb_checker #(.TAG_W(TAG_W)) u_lfb_chk (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .full(full), .out_valid(out_valid), .out_tag(out_tag),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr)
);

// File: tb/sim_commit_load_fwd_buf.sv
`timescale 1ns/1ps
module sim_commit_load_fwd_buf;
    localparam int TAG_W = 3;
    localparam int D     = 1 << TAG_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 0, fill_valid = 0, commit_valid = 0, flush_valid = 0;
    logic [TAG_W-1:0] alloc_tag = 0, fill_tag = 0, commit_tag = 0, flush_tag = 0;
    logic [31:0] alloc_addr = 0, fill_data = 0;
    logic full, out_valid;
    logic [TAG_W-1:0] out_tag;
    logic [31:0] out_addr, out_data;

    always #2 clk = ~clk;

    commit_load_fwd_buf #(.TAG_W(TAG_W), .ADDR_W(32), .DATA_W(32)) u0 (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr),
        .full(full),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .out_valid(out_valid), .out_tag(out_tag),
        .out_addr(out_addr), .out_data(out_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic [31:0] seen_addr[$];
    logic [31:0] seen_data[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_head, m_tail, m_cp;
    int m_st[D];
    bit m_cm[D];
    logic [31:0] m_addr[D], m_data[D];
    bit e_ov;
    int e_tag;
    logic [31:0] e_addr, e_data;

    always @(posedge clk) begin
        int cnt, hs, fd, oh;
        bit fok, aok, pok;
        if (rst) begin
            m_head = 0; m_tail = 0; m_cp = 0; e_ov = 0;
            for (int i = 0; i < D; i++) begin m_st[i] = 0; m_cm[i] = 0; end
        end else begin
            cnt = m_tail - m_head;
            hs  = m_head % D;
            fd  = (int'(flush_tag) - hs + D) % D;
            fok = flush_valid && (fd < cnt);
            aok = alloc_valid && (cnt != D) && !flush_valid && (int'(alloc_tag) == m_tail % D);
            pok = (cnt > 0) && (m_st[hs] == 2) && m_cm[hs] && !(fok && fd == 0);
            e_ov = pok;
            if (pok) begin e_tag = hs; e_addr = m_addr[hs]; e_data = m_data[hs]; end
            if (fill_valid && m_st[fill_tag] == 1) begin m_st[fill_tag] = 2; m_data[fill_tag] = fill_data; end
            if (commit_valid && m_st[commit_tag] != 0) begin
                m_cm[commit_tag] = 1;
                if (int'(commit_tag) == m_cp % D && m_cp < m_tail) m_cp++;
            end
            if (pok) begin m_st[hs] = 0; m_cm[hs] = 0; end
            if (fok) for (int k = fd; k < cnt; k++) begin m_st[(hs + k) % D] = 0; m_cm[(hs + k) % D] = 0; end
            if (aok) begin m_st[m_tail % D] = 1; m_cm[m_tail % D] = 0; m_addr[m_tail % D] = alloc_addr; end
            oh = m_head;
            m_head = m_head + (pok ? 1 : 0);
            m_tail = fok ? oh + fd : m_tail + (aok ? 1 : 0);
            if (m_cp > m_tail) m_cp = m_tail;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(out_valid == e_ov, "R5 out_valid vs model", out_valid, e_ov);
            if (e_ov && out_valid) begin
                chk(int'(out_tag) == e_tag, "R6 out_tag vs model", out_tag, e_tag);
                chk(out_addr == e_addr && out_data == e_data, "R6 addr/data vs model",
                    {out_addr, out_data}, {e_addr, e_data});
            end
            chk(full == (m_tail - m_head == D), "R3 full vs model", full, (m_tail - m_head == D));
            if (out_valid) begin seen_addr.push_back(out_addr); seen_data.push_back(out_data); end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] dat(input logic [31:0] a);
        return a ^ 32'hCAFE0000;
    endfunction

    task automatic tick();
        @(negedge clk);
        alloc_valid = 0; fill_valid = 0; commit_valid = 0; flush_valid = 0;
    endtask
    task automatic wait_n(input int n);
        repeat (n) tick();
    endtask
    task automatic do_alloc(input logic [31:0] a);
        alloc_valid = 1; alloc_tag = TAG_W'(m_tail % D); alloc_addr = a; tick();
    endtask
    task automatic do_fill(input int t, input logic [31:0] d);
        fill_valid = 1; fill_tag = TAG_W'(t % D); fill_data = d; tick();
    endtask
    task automatic do_commit(input int t);
        commit_valid = 1; commit_tag = TAG_W'(t % D); tick();
    endtask
    task automatic do_flush(input int t);
        flush_valid = 1; flush_tag = TAG_W'(t % D); tick();
    endtask
    task automatic clear_seen();
        seen_addr.delete(); seen_data.delete();
    endtask

    initial begin
        int b;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && full == 0, "R1 outputs during reset", {out_valid, full}, 0);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0 && full == 0, "R1 outputs after reset", {out_valid, full}, 0);

        // Out-of-order fills, in-order release (R6)
        clear_seen(); b = m_tail;
        do_alloc(32'h100); do_alloc(32'h104); do_alloc(32'h108);
        do_fill(b + 2, dat(32'h108)); do_fill(b, dat(32'h100)); do_fill(b + 1, dat(32'h104));
        do_commit(b); do_commit(b + 1); do_commit(b + 2);
        wait_n(4);
        chk(seen_addr.size() == 3 && seen_addr[0] == 32'h100 && seen_addr[1] == 32'h104
            && seen_addr[2] == 32'h108, "R6 release order", seen_addr.size(), 3);

        // Commit before fill stalls (R7), release latency (R5)
        clear_seen(); b = m_tail;
        do_alloc(32'h200); do_commit(b);
        wait_n(5);
        chk(seen_addr.size() == 0, "R7 no release before fill", seen_addr.size(), 0);
        do_fill(b, dat(32'h200));
        chk(out_valid == 0, "R5 not released one cycle after fill", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1 && out_data == dat(32'h200), "R5 released two cycles after fill",
            out_data, dat(32'h200));
        wait_n(2);

        // Wrong tag ignored (R2)
        clear_seen(); b = m_tail;
        alloc_valid = 1; alloc_tag = TAG_W'((b + 3) % D); alloc_addr = 32'h300; tick();
        do_alloc(32'h304);
        do_fill(b, dat(32'h304)); do_commit(b); do_commit(b + 1);
        wait_n(4);
        chk(seen_addr.size() == 1 && seen_addr[0] == 32'h304, "R2 wrong-tag alloc ignored",
            seen_addr.size(), 1);

        // Full and back-pressure (R3)
        clear_seen(); b = m_tail;
        for (int i = 0; i < D; i++) do_alloc(32'h400 + 32'(i * 4));
        chk(full == 1, "R3 full after all slots used", full, 1);
        do_alloc(32'h4FF);
        chk(full == 1, "R3 still full after ignored alloc", full, 1);
        for (int i = 0; i < D; i++) do_fill(b + i, dat(32'h400 + 32'(i * 4)));
        for (int i = 0; i < D; i++) do_commit(b + i);
        wait_n(4);
        chk(seen_addr.size() == D && full == 0, "R3 drained, no extra entry", seen_addr.size(), D);
        foreach (seen_addr[i]) chk(seen_addr[i] != 32'h4FF, "R3 ignored alloc never released", seen_addr[i], 0);

        // Fill rules (R4)
        clear_seen(); b = m_tail;
        do_fill(b, 32'hDEAD);
        do_alloc(32'h500);
        do_fill(b, 32'h1111); do_fill(b, 32'h2222);
        do_commit(b);
        wait_n(4);
        chk(seen_data.size() == 1 && seen_data[0] == 32'h1111, "R4 first fill kept",
            seen_data.size() == 1 ? seen_data[0] : 0, 32'h1111);

        // Squash and re-use of the tag (R8)
        clear_seen(); b = m_tail;
        for (int i = 0; i < 4; i++) do_alloc(32'h600 + 32'(i * 4));
        for (int i = 0; i < 4; i++) do_fill(b + i, dat(32'h600 + 32'(i * 4)));
        do_flush(b + 2);
        do_alloc(32'h6A0);
        do_fill(b + 2, dat(32'h6A0));
        do_commit(b); do_commit(b + 1); do_commit(b + 2); do_commit(b + 3);
        wait_n(4);
        chk(seen_addr.size() == 3 && seen_addr[0] == 32'h600 && seen_addr[1] == 32'h604
            && seen_addr[2] == 32'h6A0, "R8 squashed loads never released", seen_addr.size(), 3);

        // Out-of-range flush ignored (R9)
        clear_seen(); b = m_tail;
        do_alloc(32'h700); do_alloc(32'h704);
        do_flush(b + 5);
        do_fill(b, dat(32'h700)); do_fill(b + 1, dat(32'h704));
        do_commit(b); do_commit(b + 1);
        wait_n(4);
        chk(seen_addr.size() == 2, "R9 out-of-range flush ignored", seen_addr.size(), 2);

        // Flush beats allocation in the same cycle (R10)
        clear_seen(); b = m_tail;
        do_alloc(32'h800);
        alloc_valid = 1; alloc_tag = TAG_W'(m_tail % D); alloc_addr = 32'h804;
        flush_valid = 1; flush_tag = TAG_W'(b % D); tick();
        do_alloc(32'h808);
        do_fill(b, dat(32'h808)); do_commit(b); do_commit(b + 1);
        wait_n(4);
        chk(seen_addr.size() == 1 && seen_addr[0] == 32'h808, "R10 flush wins over alloc",
            seen_addr.size(), 1);

        // Mixed stream compared against the model each cycle
        for (int n = 0; n < 4000; n++) begin
            int cnt;
            cnt = m_tail - m_head;
            if ($urandom % 3 != 0) begin
                alloc_valid = 1; alloc_addr = $urandom;
                alloc_tag = ($urandom % 16 == 0) ? TAG_W'($urandom) : TAG_W'(m_tail % D);
            end
            if (cnt > 0 && $urandom % 2 == 0) begin
                fill_valid = 1; fill_tag = TAG_W'((m_head + int'($urandom % cnt)) % D);
                fill_data = $urandom;
            end
            if (m_cp < m_tail && $urandom % 3 == 0) begin
                commit_valid = 1; commit_tag = TAG_W'(m_cp % D);
            end
            if (m_cp < m_tail && $urandom % 25 == 0) begin
                flush_valid = 1;
                flush_tag = TAG_W'((m_cp + int'($urandom % (m_tail - m_cp))) % D);
            end
            tick();
        end
        wait_n(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule